// File: doc/BRIEF.md
# SPI Status and Error Flag Register

This block holds the eight status flags of an SPI peripheral that can run as bus master or as slave. The serial datapath around it reports what happens through one-cycle strobes: a CPU write to the transmit buffer, the move of that buffer into the shifter, the start of a slave character, a finished received character, a CPU read of the receive buffer, a multi-master mode fault, slave select going inactive together with the current bit count, and a clock-monitor timeout. From these strobes the block keeps an 8-bit status word that the CPU reads at any time.

The four error flags are cleared by writing a one into their positions. The other four bits are read-only and ignore CPU writes. When the peripheral enable is low, every flag is held at its reset value, and the transmit-empty flag reads as 0. If a hardware event sets a flag in the same cycle that the CPU tries to clear it, the hardware event wins, so no error is lost.

Top module: `spi_stat_reg`

## Requirements
- R1: After reset, with enable high, slave select inactive (ss_level=1) and no transfer running, stat_o reads 0x81. Bit layout from bit 7 down: 7 tx-empty, 6 tx-underrun, 5 collision, 4 slave-abort, 3 rx-overrun, 2 rx-not-empty, 1 transfer-active, 0 slave-select level.
- R2: A register write with a 1 in bit 6, 5, 4 or 3 of reg_wdata clears that flag. A 0 in those positions leaves the flag unchanged.
- R3: Register writes have no effect on bits 7, 2, 1 and 0.
- R4: tx_wr clears bit 7 and tx_load sets it. While enable is low, bit 7 reads 0.
- R5: In slave mode, char_start while bit 7 is 1 sets bit 6. It does not set bit 6 when bit 7 is 0 or when the block is in master mode.
- R6: rx_done sets bit 2 and rx_rd clears it. rx_done while bit 2 is already 1 also sets bit 3.
- R7: In slave mode with transfer active, ss_deassert sets bit 4 when bit_cnt is below the character length. char_len 0 means 8 bits, and values 1 to 7 mean that many bits. ss_deassert does not set bit 4 when bit_cnt has reached the length or when the block is in master mode.
- R8: In slave mode, sck_timeout sets bit 4 only when multi_master_en is 0 and baud_ctl is 1.
- R9: mode_fault sets bit 5.
- R10: One cycle after enable is sampled low, stat_o reads 0x01 and stays there while enable remains low.
- R11: When a hardware event sets a flag in the same cycle that a write-one or read clear targets it, the flag ends up set.
- R12: Bits 1 and 0 follow xfer_active and ss_level with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; low forces reset values |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| multi_master_en | input | 1 | Multi-master enable, gates the timeout abort |
| baud_ctl | input | 1 | Baud-control bit, gates the timeout abort |
| char_len | input | 3 | Character length, 0 = 8 bits |
| xfer_active | input | 1 | A transfer is in progress |
| ss_level | input | 1 | Slave-select pin level |
| bit_cnt | input | 4 | Bits shifted so far in the current character |
| tx_wr | input | 1 | CPU wrote the transmit buffer |
| tx_load | input | 1 | Transmit buffer moved into the shifter |
| char_start | input | 1 | Slave character begins |
| rx_done | input | 1 | Received character written to the receive buffer |
| rx_rd | input | 1 | CPU read the receive buffer |
| mode_fault | input | 1 | Multi-master mode fault detected |
| ss_deassert | input | 1 | Slave select went inactive |
| sck_timeout | input | 1 | SCK monitor timeout |
| reg_wr | input | 1 | CPU write to the status register |
| reg_wdata | input | 8 | Data of that write |
| stat_o | output | 8 | Status word |

## Verification
A CPU write-one-to-clear can meet a hardware set of the same flag in one cycle: collision with a mode fault, and the receive-not-empty clear from a buffer read with a new character arriving. The bench drives both strobes in the same cycle and expects the flag to read 1 afterwards. It then clears the flag on its own to show that the clear path works by itself.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 8;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = LEN_W + 1;

  localparam int B_TDE  = 7;
  localparam int B_UNDR = 6;
  localparam int B_COLL = 5;
  localparam int B_ABRT = 4;
  localparam int B_OVR  = 3;
  localparam int B_RNE  = 2;
  localparam int B_XACT = 1;
  localparam int B_SSL  = 0;

  localparam logic [STAT_W-1:0] STAT_RST  = 8'h81;
  localparam logic [STAT_W-1:0] W1C_MASK  = 8'h78;

  // A length code of zero stands for the widest character.
  function automatic logic [CNT_W-1:0] char_bits(input logic [LEN_W-1:0] len);
    if (len == '0) return CNT_W'(1 << LEN_W);
    return {1'b0, len};
  endfunction

  function automatic logic char_short(input logic [CNT_W-1:0] cnt,
                                      input logic [LEN_W-1:0] len);
    return cnt < char_bits(len);
  endfunction
endpackage

// File: rtl/spi_stat_evt.sv
module spi_stat_evt
  import spi_stat_pkg::*;
(
  input  logic             slave_mode,
  input  logic             multi_master_en,
  input  logic             baud_ctl,
  input  logic [LEN_W-1:0] char_len,
  input  logic             xfer_active,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             char_start,
  input  logic             rx_done,
  input  logic             mode_fault,
  input  logic             ss_deassert,
  input  logic             sck_timeout,
  input  logic             tde_now,
  input  logic             rne_now,
  output logic             ev_underrun,
  output logic             ev_overrun,
  output logic             ev_abort,
  output logic             ev_collision
);
  logic cut_short;
  logic mon_abort;

  always_comb begin
    cut_short    = slave_mode && xfer_active && ss_deassert && char_short(bit_cnt, char_len);
    mon_abort    = slave_mode && sck_timeout && !multi_master_en && baud_ctl;
    ev_abort     = cut_short || mon_abort;
    ev_underrun  = slave_mode && char_start && tde_now;
    ev_overrun   = rx_done && rne_now;
    ev_collision = mode_fault;
  end
endmodule

// File: rtl/spi_stat_bit.sv
module spi_stat_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= RST_VAL;
    else if (!enable) q_o <= RST_VAL;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              slave_mode,
  input  logic              multi_master_en,
  input  logic              baud_ctl,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              xfer_active,
  input  logic              ss_level,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              tx_wr,
  input  logic              tx_load,
  input  logic              char_start,
  input  logic              rx_done,
  input  logic              rx_rd,
  input  logic              mode_fault,
  input  logic              ss_deassert,
  input  logic              sck_timeout,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] flag_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] w1c_hit;
  logic ev_underrun, ev_overrun, ev_abort, ev_collision;

  spi_stat_evt u_evt (
    .slave_mode      (slave_mode),
    .multi_master_en (multi_master_en),
    .baud_ctl        (baud_ctl),
    .char_len        (char_len),
    .xfer_active     (xfer_active),
    .bit_cnt         (bit_cnt),
    .char_start      (char_start),
    .rx_done         (rx_done),
    .mode_fault      (mode_fault),
    .ss_deassert     (ss_deassert),
    .sck_timeout     (sck_timeout),
    .tde_now         (flag_q[B_TDE]),
    .rne_now         (flag_q[B_RNE]),
    .ev_underrun     (ev_underrun),
    .ev_overrun      (ev_overrun),
    .ev_abort        (ev_abort),
    .ev_collision    (ev_collision)
  );

  assign w1c_hit = (reg_wr ? reg_wdata : '0) & W1C_MASK;

  always_comb begin
    set_vec = '0;
    clr_vec = w1c_hit;
    set_vec[B_TDE]  = tx_load;
    clr_vec[B_TDE]  = tx_wr;
    set_vec[B_UNDR] = ev_underrun;
    set_vec[B_COLL] = ev_collision;
    set_vec[B_ABRT] = ev_abort;
    set_vec[B_OVR]  = ev_overrun;
    set_vec[B_RNE]  = rx_done;
    clr_vec[B_RNE]  = rx_rd;
    set_vec[B_XACT] = xfer_active;
    clr_vec[B_XACT] = !xfer_active;
    set_vec[B_SSL]  = ss_level;
    clr_vec[B_SSL]  = !ss_level;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    spi_stat_bit #(.RST_VAL(STAT_RST[i])) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .q_o    (flag_q[i])
    );
  end

  always_comb begin
    stat_o        = flag_q;
    stat_o[B_TDE] = flag_q[B_TDE] && enable;
  end
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       tx_wr,
  input logic       tx_load,
  input logic       rx_done,
  input logic       rx_rd,
  input logic       ev_underrun,
  input logic       ev_overrun,
  input logic       ev_abort,
  input logic       ev_collision,
  input logic [7:0] stat_o
);
  AST_DISABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> stat_o[6:0] == 7'h01); // R10
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && reg_wr && reg_wdata[5] && !ev_collision |=> !stat_o[5]); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_collision |=> stat_o[5]); // R11
  AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_abort |=> stat_o[4]); // R7
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_overrun |=> stat_o[3]); // R6
  AST_RNE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && rx_rd && !rx_done |=> !stat_o[2]); // R6
  AST_TDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && tx_wr && !tx_load |=> !stat_o[7]); // R4
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_underrun |=> stat_o[6]); // R5
endmodule

bind spi_stat_reg spi_stat_chk u_chk (.*);

// File: tb/sim_spi_stat_reg.sv
module sim_spi_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable, slave_mode, multi_master_en, baud_ctl;
  logic [2:0] char_len;
  logic xfer_active, ss_level;
  logic [3:0] bit_cnt;
  logic tx_wr, tx_load, char_start, rx_done, rx_rd, mode_fault, ss_deassert, sck_timeout, reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] stat_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  spi_stat_reg u0 (.*);

  // strobes: tx_wr tx_load char_start rx_done rx_rd mode_fault ss_deassert sck_timeout reg_wr
  localparam int NV = 20;
  localparam logic [28:0] VT [NV] = '{
    {9'b000000000, 8'h00, 4'd0, 8'h83},
    {9'b100000000, 8'h00, 4'd0, 8'h03},
    {9'b001000000, 8'h00, 4'd0, 8'h03},
    {9'b010000000, 8'h00, 4'd0, 8'h83},
    {9'b001000000, 8'h00, 4'd0, 8'hC3},
    {9'b000100000, 8'h00, 4'd0, 8'hC7},
    {9'b000100000, 8'h00, 4'd0, 8'hCF},
    {9'b000010000, 8'h00, 4'd0, 8'hCB},
    {9'b000000100, 8'h00, 4'd3, 8'hDB},
    {9'b000000001, 8'h10, 4'd0, 8'hCB},
    {9'b000000100, 8'h00, 4'd5, 8'hCB},
    {9'b000001000, 8'h00, 4'd0, 8'hEB},
    {9'b000000001, 8'h00, 4'd0, 8'hEB},
    {9'b000000001, 8'h87, 4'd0, 8'hEB},
    {9'b000000001, 8'h48, 4'd0, 8'hA3},
    {9'b000000010, 8'h00, 4'd0, 8'hB3},
    {9'b000000001, 8'h30, 4'd0, 8'h83},
    {9'b000001001, 8'h20, 4'd0, 8'hA3},
    {9'b000110000, 8'h00, 4'd0, 8'hA7},
    {9'b000000001, 8'h20, 4'd0, 8'h87}
  };

  task automatic idle();
    {tx_wr, tx_load, char_start, rx_done, rx_rd, mode_fault, ss_deassert, sck_timeout, reg_wr} = '0;
    reg_wdata = 8'h00;
    bit_cnt = 4'd0;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (stat_o !== exp) begin
      fails++;
      $display("FAIL %s: stat_o=%h expected %h", req, stat_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
    finish_run();
  end

  initial begin
    enable = 1'b1; slave_mode = 1'b1; multi_master_en = 1'b0; baud_ctl = 1'b1;
    char_len = 3'd5; xfer_active = 1'b0; ss_level = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", 8'h81);
    xfer_active = 1'b1;
    step();
    check("R12 transfer bit follows", 8'h83);

    // table: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      {tx_wr, tx_load, char_start, rx_done, rx_rd, mode_fault, ss_deassert, sck_timeout, reg_wr} = VT[i][28:20];
      reg_wdata = VT[i][19:12];
      bit_cnt   = VT[i][11:8];
      step();
      check($sformatf("R2-table vector %0d", i), VT[i][7:0]);
    end

    rx_rd = 1'b1; step();
    check("R6 read clears rx-not-empty", 8'h83);

    // R7: length code 0 means 8 bits
    char_len = 3'd0; ss_deassert = 1'b1; bit_cnt = 4'd7; step();
    check("R7 len0 cut at 7", 8'h93);
    reg_wr = 1'b1; reg_wdata = 8'h10; step();
    ss_deassert = 1'b1; bit_cnt = 4'd8; step();
    check("R7 len0 full char no abort", 8'h83);
    slave_mode = 1'b0; ss_deassert = 1'b1; bit_cnt = 4'd1; step();
    check("R7 master mode no abort", 8'h83);
    char_start = 1'b1; step();
    check("R5 master mode no underrun", 8'h83);
    slave_mode = 1'b1;

    // R8 gating
    multi_master_en = 1'b1; sck_timeout = 1'b1; step();
    check("R8 timeout blocked by multi-master", 8'h83);
    multi_master_en = 1'b0; baud_ctl = 1'b0; sck_timeout = 1'b1; step();
    check("R8 timeout blocked by baud bit", 8'h83);
    baud_ctl = 1'b1;

    // R12 mirror bits
    xfer_active = 1'b0; ss_level = 1'b0;
    #1 check("R12 no same-cycle change", 8'h83);
    step();
    check("R12 mirrors follow", 8'h80);

    // R10 / R4 disable
    mode_fault = 1'b1; step();
    check("R9 collision", 8'hA0);
    enable = 1'b0;
    #1 check("R4 tx-empty masked when disabled", 8'h20);
    ss_level = 1'b1; xfer_active = 1'b1; step();
    check("R10 disable forces reset", 8'h01);
    mode_fault = 1'b1; rx_done = 1'b1; step();
    check("R10 held while disabled", 8'h01);
    enable = 1'b0; xfer_active = 1'b0;
    enable = 1'b1;
    #1 check("R1 re-enable value", 8'h81);
    step();
    check("R1 re-enabled idle", 8'h81);

    finish_run();
  end
endmodule